// File: doc/BRIEF.md
# Write-Back Cache with Per-Line Volatile Marking

This block is a small set-associative write-back cache that sits between one requester and a word-wide memory. Each line keeps three state bits: valid, dirty and volatile. Every request carries a volatile qualifier. An access with the qualifier set marks the line it fills or hits as volatile. An access with the qualifier clear, when it hits, takes the mark away. Traffic that belongs to one class, such as a compute job sharing the cache with graphics work, can then be marked and later dealt with on its own.

Two maintenance commands look only at marked lines. A drop command clears every volatile line and throws away any dirty data it holds. A flush command writes each dirty volatile line back to memory and leaves that line resident, clean and still marked. Unmarked lines are never touched by either command.

A command steps through every line in turn, one line per cycle, plus any cycles spent waiting on memory. While a command runs, the cache accepts no requests. Replacement is round-robin within each set. A line is one data word. `SETS` and `WAYS` must be powers of two, with `WAYS` at least 2.

Top module: `vc_cache`

Back-pressure rules:
- Request port: a request is taken on a cycle where `req_valid` and `req_ready` are both high. The requester must hold the request fields stable while `req_valid` is high and `req_ready` is low.
- Response port: it has no back-pressure. `rsp_valid` is a one-cycle pulse.
- Memory port: the cache holds `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` stable until `mem_ready` is high. For a read, `mem_rdata` is taken in the cycle where `mem_valid` and `mem_ready` are both high.

## Requirements
- R1: After reset, every line is invalid, `req_ready` is 1, and `cmd_busy`, `cmd_done`, `rsp_valid` and `mem_valid` are all 0.
- R2: A read returns the last value written to that address. Each accepted request gives exactly one `rsp_valid` pulse. On a hit, the pulse comes one cycle after acceptance.
- R3: An access with `req_vol`=1 marks the line it touches as volatile, whether that access hits or misses.
- R4: An access with `req_vol`=0 that hits a volatile line removes its volatile mark.
- R5: A drop command (`cmd_op`=0) invalidates every volatile line. Dirty data in those lines is discarded, and the command issues no memory write.
- R6: A flush command (`cmd_op`=1) writes back exactly the dirty volatile lines. Each such line stays valid, becomes clean and keeps its volatile mark, so a second flush right after the first issues no writes.
- R7: Lines without the volatile mark stay resident, keep their data and are not written back during either command.
- R8: While `cmd_busy` is 1, `req_ready` is 0. A command lasts at least `SETS*WAYS` cycles. It ends with one `cmd_done` pulse, given as `cmd_busy` falls.
- R9: Each set replaces its ways in round-robin order, starting from way 0 after reset. A dirty victim is written back before it is replaced, whatever its volatile mark.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, the memory request fields hold their values into the next cycle.
- R11: When `cmd_start` and `req_valid` are both high in an idle cycle, the command wins. `req_ready` is 0 in that cycle and no response follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache accepts the request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vol | input | 1 | Volatile qualifier for this access |
| req_addr | input | ADDR_W | Word address; the low SET_W bits select the set |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Read data (echoes the written data on a write) |
| mem_valid | output | 1 | Memory request present |
| mem_ready | input | 1 | Memory takes the request this cycle |
| mem_write | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write-back data |
| mem_rdata | input | DATA_W | Refill data, valid in the handshake cycle |
| cmd_start | input | 1 | Start a maintenance command |
| cmd_op | input | 1 | 0 = drop volatile lines, 1 = flush volatile lines |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | One-cycle pulse at the end of a command |

## Verification
The embedded properties check on every cycle that:
- the memory request stays stable under back-pressure;
- requests are blocked while a command runs;
- a command ends with a single done pulse;
- a drop command never drives the memory port;
- a command takes priority over a request that arrives in the same idle cycle.

Other behaviour depends on line state built up over many accesses, so only the bench scenarios can show it. This covers:
- that dirty volatile data is lost after a drop;
- that a flush writes back exactly the marked dirty lines and that a second flush writes none;
- that a hit can set or clear the volatile mark;
- the round-robin order in which victims leave a set.

A sweep over the whole address space, with marking mixed across addresses, confirms that reads stay coherent through many evictions.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_EVICT  = 2'd1,
    ST_REFILL = 2'd2,
    ST_WALK   = 2'd3
  } vc_state_e;

  typedef enum logic {
    OP_DROP  = 1'b0,
    OP_FLUSH = 1'b1
  } vc_op_e;
endpackage

// File: rtl/vc_way_match.sv
module vc_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 6,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS*TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tag[w*TAG_W +: TAG_W] == look_tag);
  end

  always_comb begin
    hit     = |match;
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/vc_rr_victim.sv
module vc_rr_victim #(
  parameter int SETS  = 4,
  parameter int WAYS  = 2,
  parameter int SET_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [SET_W-1:0] adv_set,
  input  logic [SET_W-1:0] look_set,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr [SETS];

  assign victim = ptr[look_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr[s] <= '0;
    end else if (adv) begin
      ptr[adv_set] <= (ptr[adv_set] == WAY_W'(WAYS-1)) ? '0 : ptr[adv_set] + 1'b1;
    end
  end
endmodule

// File: rtl/vc_cache.sv
module vc_cache
  import vc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SETS   = 4,
  parameter int WAYS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_vol,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cmd_start,
  input  logic              cmd_op,
  output logic              cmd_busy,
  output logic              cmd_done
);
  localparam int SET_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - SET_W;
  localparam int LINES  = SETS * WAYS;
  localparam int LINE_W = SET_W + WAY_W;

  vc_state_e state;
  vc_op_e    op_q;

  logic [LINES-1:0]  lv, ld, lvol;
  logic [TAG_W-1:0]  ltag  [LINES];
  logic [DATA_W-1:0] ldata [LINES];

  logic              q_write, q_vol;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [WAY_W-1:0]  vic_q;
  logic [LINE_W-1:0] walk;

  logic [SET_W-1:0] req_set, q_set;
  logic [TAG_W-1:0] req_tag;
  assign req_set = req_addr[SET_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:SET_W];
  assign q_set   = q_addr[SET_W-1:0];

  // Per-way lookup for the requested set
  logic [WAYS-1:0]       set_v;
  logic [WAYS*TAG_W-1:0] set_t;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      set_v[w]                 = lv[{req_set, WAY_W'(w)}];
      set_t[w*TAG_W +: TAG_W]  = ltag[{req_set, WAY_W'(w)}];
    end
  end

  logic             hit;
  logic [WAY_W-1:0] hit_way, rr_way;

  vc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .way_valid(set_v), .way_tag(set_t), .look_tag(req_tag),
    .hit(hit), .hit_way(hit_way)
  );

  logic [LINE_W-1:0] hline, rline, vline;
  assign hline = {req_set, hit_way};
  assign rline = {req_set, rr_way};
  assign vline = {q_set, vic_q};

  assign req_ready = (state == ST_IDLE) && !cmd_start;
  assign cmd_busy  = (state == ST_WALK);

  logic acc;
  assign acc = req_valid && req_ready;

  // Line install: clean write miss in idle, or the end of an eviction/refill
  logic              inst_en, idirty, ivol;
  logic [LINE_W-1:0] il;
  logic [TAG_W-1:0]  itag;
  logic [DATA_W-1:0] idata;
  logic              fast_wr_miss;
  assign fast_wr_miss = (state == ST_IDLE) && acc && !hit && req_write && !(lv[rline] && ld[rline]);

  always_comb begin
    inst_en = fast_wr_miss
            || ((state == ST_EVICT) && mem_ready && q_write)
            || ((state == ST_REFILL) && mem_ready);
    if (fast_wr_miss) begin
      il = rline; itag = req_tag; idata = req_wdata; ivol = req_vol; idirty = 1'b1;
    end else begin
      il = vline; itag = q_addr[ADDR_W-1:SET_W];
      idata = q_write ? q_wdata : mem_rdata; ivol = q_vol; idirty = q_write;
    end
  end

  vc_rr_victim #(.SETS(SETS), .WAYS(WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv(inst_en), .adv_set(il[LINE_W-1:WAY_W]),
    .look_set(req_set), .victim(rr_way)
  );

  // Walker: flush needs memory only for dirty volatile lines
  logic flush_need, walk_step;
  assign flush_need = (op_q == OP_FLUSH) && lv[walk] && lvol[walk] && ld[walk];
  assign walk_step  = !flush_need || mem_ready;

  // Memory port
  always_comb begin
    mem_valid = 1'b0;
    mem_write = 1'b1;
    mem_addr  = q_addr;
    mem_wdata = ldata[vline];
    case (state)
      ST_EVICT: begin
        mem_valid = 1'b1;
        mem_addr  = {ltag[vline], q_set};
      end
      ST_REFILL: begin
        mem_valid = 1'b1;
        mem_write = 1'b0;
      end
      ST_WALK: begin
        mem_valid = flush_need;
        mem_addr  = {ltag[walk], walk[LINE_W-1:WAY_W]};
        mem_wdata = ldata[walk];
      end
      default: ;
    endcase
  end

  // Tag and data arrays
  always_ff @(posedge clk) begin
    if (inst_en) begin
      ltag[il]  <= itag;
      ldata[il] <= idata;
    end else if ((state == ST_IDLE) && acc && hit && req_write) begin
      ldata[hline] <= req_wdata;
    end
  end

  // Control and line state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; op_q <= OP_DROP;
      lv <= '0; ld <= '0; lvol <= '0;
      q_write <= 1'b0; q_vol <= 1'b0; q_addr <= '0; q_wdata <= '0;
      vic_q <= '0; walk <= '0;
      rsp_valid <= 1'b0; rsp_rdata <= '0; cmd_done <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      cmd_done  <= 1'b0;
      if (inst_en) begin
        lv[il] <= 1'b1; ld[il] <= idirty; lvol[il] <= ivol;
        rsp_valid <= 1'b1; rsp_rdata <= idata;
      end
      case (state)
        ST_IDLE: begin
          if (cmd_start) begin
            op_q  <= vc_op_e'(cmd_op);
            walk  <= '0;
            state <= ST_WALK;
          end else if (req_valid) begin
            q_write <= req_write; q_vol <= req_vol;
            q_addr  <= req_addr;  q_wdata <= req_wdata;
            vic_q   <= rr_way;
            if (hit) begin
              lvol[hline] <= req_vol;
              if (req_write) ld[hline] <= 1'b1;
              rsp_valid <= 1'b1;
              rsp_rdata <= req_write ? req_wdata : ldata[hline];
            end else if (lv[rline] && ld[rline]) begin
              state <= ST_EVICT;
            end else if (!req_write) begin
              state <= ST_REFILL;
            end
          end
        end
        ST_EVICT: if (mem_ready) state <= q_write ? ST_IDLE : ST_REFILL;
        ST_REFILL: if (mem_ready) state <= ST_IDLE;
        ST_WALK: begin
          if (op_q == OP_DROP) begin
            if (lvol[walk]) begin
              lv[walk] <= 1'b0; ld[walk] <= 1'b0; lvol[walk] <= 1'b0;
            end
          end else if (flush_need && mem_ready) begin
            ld[walk] <= 1'b0;
          end
          if (walk_step) begin
            if (walk == LINE_W'(LINES-1)) begin
              state    <= ST_IDLE;
              cmd_done <= 1'b1;
            end else begin
              walk <= walk + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

  // R8
  busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |-> !req_ready);

  // R8
  done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> (!cmd_busy && $past(cmd_busy)));

  // R5
  drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_busy && op_q == OP_DROP) |-> !mem_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_busy);

  // R11
  cmd_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && req_valid && state == ST_IDLE) |=> (cmd_busy && !rsp_valid));
endmodule

// File: tb/vc_cache_test.sv
module vc_cache_test;
  localparam int AW = 8, DW = 16, SETS = 4, WAYS = 2, LINES = SETS * WAYS;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_vol = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_valid, mem_write, cmd_busy, cmd_done;
  logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_ready = 1'b1, cmd_start = 1'b0, cmd_op = 1'b0;

  vc_cache #(.ADDR_W(AW), .DATA_W(DW), .SETS(SETS), .WAYS(WAYS)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_vol(req_vol),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cmd_start(cmd_start), .cmd_op(cmd_op), .cmd_busy(cmd_busy), .cmd_done(cmd_done)
  );

  logic [DW-1:0] mem  [256];
  logic [DW-1:0] gold [256];
  int wr_cnt = 0, tick = 0, hold_err = 0, cyc = 0;
  int checks = 0, fails = 0;
  logic pend = 0;
  logic [AW-1:0] p_addr; logic p_wr; logic [DW-1:0] p_data;

  function automatic logic [DW-1:0] init_val(int a);
    return DW'((a * 257) ^ 16'h5a3c);
  endfunction

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (mem_valid && mem_ready && mem_write) begin
      mem[mem_addr] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (pend && (!mem_valid || mem_addr != p_addr || mem_write != p_wr || mem_wdata != p_data))
      hold_err <= hold_err + 1;
    pend   <= mem_valid && !mem_ready;
    p_addr <= mem_addr; p_wr <= mem_write; p_data <= mem_wdata;
  end

  // memory back-pressure pattern
  always @(negedge clk) begin
    tick++;
    mem_ready = (tick % 3) != 0;
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic vol, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] q, output int lat);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_vol = vol; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0; lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    q = rsp_rdata;
    if (wr) gold[a] = d;
  endtask

  task automatic command(input logic op, output int cycles, output int writes);
    int w0;
    @(negedge clk);
    cmd_start = 1; cmd_op = op; w0 = wr_cnt;
    @(negedge clk);
    cmd_start = 0; cycles = 1;
    while (!cmd_done) begin @(negedge clk); cycles++; end
    writes = wr_cnt - w0;
  endtask

  initial begin
    logic [DW-1:0] q;
    int lat, cyc_n, nw;
    for (int i = 0; i < 256; i++) begin mem[i] = init_val(i); gold[i] = init_val(i); end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready === 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk(cmd_busy === 1'b0 && cmd_done === 1'b0, "R1 cmd idle", int'({cmd_busy, cmd_done}), 0);
    chk(rsp_valid === 1'b0 && mem_valid === 1'b0, "R1 outputs", int'({rsp_valid, mem_valid}), 0);
    rst_n = 1;
    // R1 no line valid: first read is a miss
    access(0, 0, 8'd0, 0, q, lat);
    chk(lat > 1 && q == init_val(0), "R1 empty cache miss", lat, 2);

    // R9 round-robin in set 0 (addr[1:0]=0)
    access(1, 0, 8'd4,  16'hA004, q, lat);
    access(1, 0, 8'd0,  16'hA000, q, lat);   // hit, way0 dirty
    access(1, 0, 8'd8,  16'hA008, q, lat);   // evicts way0 (addr 0)
    chk(mem[0] == 16'hA000, "R9 evict way0", mem[0], 16'hA000);
    access(1, 1, 8'd12, 16'hA00C, q, lat);   // evicts way1 (addr 4)
    chk(mem[4] == 16'hA004, "R9 evict way1", mem[4], 16'hA004);
    access(1, 1, 8'd16, 16'hA010, q, lat);   // evicts addr 8
    chk(mem[8] == 16'hA008, "R9 evict addr8", mem[8], 16'hA008);
    access(1, 0, 8'd20, 16'hA014, q, lat);   // evicts volatile dirty addr 12
    chk(mem[12] == 16'hA00C, "R9 volatile victim written", mem[12], 16'hA00C);

    // R6 flush
    access(1, 1, 8'd1, 16'hB001, q, lat);
    access(0, 0, 8'd5, 0, q, lat);
    command(1, cyc_n, nw);
    chk(nw == 2, "R6 flush write count", nw, 2);
    chk(mem[16] == 16'hA010 && mem[1] == 16'hB001, "R6 flushed data", mem[1], 16'hB001);
    chk(mem[20] == init_val(20), "R7 unmarked not flushed", mem[20], init_val(20));
    chk(cyc_n >= LINES, "R8 walk length", cyc_n, LINES);
    command(1, cyc_n, nw);
    chk(nw == 0, "R6 second flush silent", nw, 0);
    access(0, 1, 8'd16, 0, q, lat);
    chk(lat == 1 && q == 16'hA010, "R6 line stays resident", int'(q), 16'hA010);

    // R5 drop discards dirty volatile data
    access(1, 1, 8'd1, 16'hC001, q, lat);
    command(0, cyc_n, nw);
    chk(nw == 0, "R5 drop issues no writes", nw, 0);
    gold[1] = mem[1];
    access(0, 0, 8'd1, 0, q, lat);
    chk(q == 16'hB001 && lat > 1, "R5 dropped data lost", int'(q), 16'hB001);
    access(0, 0, 8'd20, 0, q, lat);
    chk(q == 16'hA014 && lat == 1, "R7 unmarked line survives drop", int'(q), 16'hA014);

    // R4 unmarked hit clears mark
    access(1, 1, 8'd2, 16'hD002, q, lat);
    access(0, 0, 8'd2, 0, q, lat);
    chk(lat == 1 && q == 16'hD002, "R2 hit latency", lat, 1);
    command(0, cyc_n, nw);
    access(0, 0, 8'd2, 0, q, lat);
    chk(q == 16'hD002 && lat == 1, "R4 mark cleared by hit", int'(q), 16'hD002);

    // R3 marked hit sets mark
    access(1, 0, 8'd3, 16'hE003, q, lat);
    access(0, 1, 8'd3, 0, q, lat);
    command(0, cyc_n, nw);
    gold[3] = mem[3];
    access(0, 0, 8'd3, 0, q, lat);
    chk(q == init_val(3), "R3 mark set by hit", int'(q), int'(init_val(3)));

    // R11 command wins over simultaneous request
    @(negedge clk);
    cmd_start = 1; cmd_op = 1;
    req_valid = 1; req_write = 0; req_vol = 0; req_addr = 8'd20;
    #1;
    chk(req_ready === 1'b0, "R11 request held off", int'(req_ready), 0);
    @(negedge clk);
    cmd_start = 0;
    chk(cmd_busy === 1'b1 && rsp_valid === 1'b0, "R11 command started", int'({cmd_busy, rsp_valid}), 2);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == 16'hA014, "R11 request served after command", int'(rsp_rdata), 16'hA014);

    // R2 sweep over all addresses with mixed marking
    for (int a = 0; a < 256; a++)
      access(1, a[2], AW'(a), DW'(a * 3 + 7) ^ 16'h1234, q, lat);
    command(1, cyc_n, nw);
    command(0, cyc_n, nw);
    for (int a = 0; a < 256; a++) begin
      access(0, a[3], AW'(a), 0, q, lat);
      chk(q == gold[a], "R2 sweep read", int'(q), int'(gold[a]));
    end

    chk(hold_err == 0, "R10 memory request held", hold_err, 0);
    summary();
    $finish;
  end
endmodule